// File: doc/BRIEF.md
# Bridge Off-Time Decay and Rectifier Controller

This block decides what the four switches of one full bridge do while the bridge is in its PWM off-time. Outside the off-time it passes the on-phase gate pattern from the current regulator straight through. A single-cycle start pulse begins an off-time of a fixed length. During it, the winding current recirculates either through the two low-side switches (slow decay), or, in mixed decay, first through the diagonal opposite to the on-phase drive (fast decay) for a programmable time and then through the low sides.

A two-bit rectification policy decides whether the recirculation switches are driven at all, and when they are released. One policy releases them when the current reaches zero. A second lets the current reverse and releases them when the reversed current reaches the trip level. The third never drives them. Over-temperature and undervoltage faults force every gate off. Every move between two different non-empty switch patterns passes through one clock with all gates off, so that no leg ever conducts from supply to ground.

Top module: `decay_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after reset, `gate_en` is 0000 and `off_phase` is 0.
- R2: When no off-time is running, `gate_en` follows `on_gates` one clock later, subject to R10. Gate bit positions: bit 0 A-high, bit 1 A-low, bit 2 B-high, bit 3 B-low.
- R3: In the slow-decay phase of an off-time with rectification enabled, `gate_en` is 1010, meaning both low sides are on.
- R4: When `decay_mixed` is 1, the first `fd_code`×FD_TICK cycles of the off-time are fast decay. With `cur_dir`=1, `gate_en` is 0110; with `cur_dir`=0, it is 1001. Afterwards the off-time continues as slow decay.
- R5: If the fast-decay time is at least the off-time, the whole off-time is fast decay. If `fd_code` is 0, the whole off-time is slow decay.
- R6: An off-time started by `off_start` lasts max(`off_len`,1) cycles, shown on `off_phase`. After it, `gate_en` returns to `on_gates`.
- R7: With `sr_mode`=00 (active), a `zero_det` seen during the off-time turns all gates off for the rest of that off-time. `rev_trip` has no effect in this mode.
- R8: With `sr_mode`=01 (passive), a `rev_trip` seen during the off-time turns all gates off for the rest of that off-time. `zero_det` has no effect in this mode.
- R9: With `sr_mode`=10 or 11 (disabled), `gate_en` is 0000 throughout the off-time.
- R10: A change of `gate_en` between two different non-zero patterns always passes through exactly one cycle of 0000.
- R11: `ot_fault` or `uv_fault` high drives `gate_en` to 0000 on the next clock. Off-time timing keeps running while a fault is present.
- R12: An `off_start` pulse during an off-time restarts both timers and clears a released-rectifier state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| off_start | input | 1 | One-cycle pulse starting an off-time |
| off_len | input | OFF_W | Off-time length in clocks |
| decay_mixed | input | 1 | 1 selects mixed decay, 0 slow decay |
| fd_code | input | CODE_W | Fast-decay time code, in units of FD_TICK clocks |
| sr_mode | input | 2 | Rectification policy: 00 active, 01 passive, 1x disabled |
| cur_dir | input | 1 | On-phase current direction (1: A-high/B-low drive) |
| zero_det | input | 1 | Winding current has reached zero |
| rev_trip | input | 1 | Reversed current has reached the trip level |
| ot_fault | input | 1 | Over-temperature fault |
| uv_fault | input | 1 | Undervoltage fault |
| on_gates | input | 4 | On-phase gate pattern from the regulator |
| gate_en | output | 4 | Registered gate enables for the bridge |
| off_phase | output | 1 | High while an off-time is running |

## Verification
A wrong timer count shows up at the ports within one clock. The fast-to-slow step then moves by whole cycles, or `off_phase` falls at the wrong time, and a dead cycle appears where none belongs. A released-rectifier flag that sets or clears wrongly shows as a missing or spurious 0000 two clocks after the flag pulse, or as gates that stay off into the next off-time. The bench compares both outputs against an independently written cycle model on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/decay_pkg.sv
package decay_pkg;

  localparam int GATE_W = 4;
  localparam int GI_AH  = 0;
  localparam int GI_AL  = 1;
  localparam int GI_BH  = 2;
  localparam int GI_BL  = 3;

  typedef enum logic [1:0] {
    SR_ACTIVE  = 2'b00,
    SR_PASSIVE = 2'b01,
    SR_NONE_A  = 2'b10,
    SR_NONE_B  = 2'b11
  } sr_mode_e;

  // Fast decay drives the diagonal opposite to the on-phase one.
  function automatic logic [GATE_W-1:0] fast_pattern(input logic dir);
    logic [GATE_W-1:0] p;
    p = '0;
    if (dir) begin
      p[GI_AL] = 1'b1;
      p[GI_BH] = 1'b1;
    end else begin
      p[GI_AH] = 1'b1;
      p[GI_BL] = 1'b1;
    end
    return p;
  endfunction

  function automatic logic [GATE_W-1:0] slow_pattern();
    logic [GATE_W-1:0] p;
    p = '0;
    p[GI_AL] = 1'b1;
    p[GI_BL] = 1'b1;
    return p;
  endfunction

endpackage

// File: rtl/decay_timer.sv
module decay_timer #(
  parameter int OFF_W   = 8,
  parameter int CODE_W  = 4,
  parameter int FD_TICK = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mixed,
  input  logic [OFF_W-1:0]  off_len,
  input  logic [CODE_W-1:0] fd_code,
  output logic              in_off,
  output logic              fast,
  output logic              ending
);

  localparam int FD_W = CODE_W + $clog2(FD_TICK) + 1;

  logic [OFF_W-1:0] off_cnt_q;
  logic [FD_W-1:0]  fd_cnt_q;
  logic             in_off_q;
  logic [FD_W-1:0]  fd_load;

  assign fd_load = FD_W'(fd_code) * FD_W'(FD_TICK);
  assign ending  = in_off_q && (off_cnt_q <= OFF_W'(1));
  assign in_off  = in_off_q;
  assign fast    = in_off_q && mixed && (fd_cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_off_q  <= 1'b0;
      off_cnt_q <= '0;
      fd_cnt_q  <= '0;
    end else if (start) begin
      in_off_q  <= 1'b1;
      off_cnt_q <= off_len;
      fd_cnt_q  <= fd_load;
    end else if (in_off_q) begin
      if (ending) begin
        in_off_q  <= 1'b0;
        off_cnt_q <= '0;
        fd_cnt_q  <= '0;
      end else begin
        off_cnt_q <= off_cnt_q - OFF_W'(1);
        fd_cnt_q  <= (fd_cnt_q != '0) ? fd_cnt_q - FD_W'(1) : '0;
      end
    end
  end

  AST_OFF_ENDS: assert property (@(posedge clk) disable iff (rst)
    (in_off_q && off_cnt_q <= OFF_W'(1) && !start) |=> !in_off_q); // R6

  AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
    start |=> in_off_q); // R12

endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import decay_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       ending,
  input  logic       in_off,
  input  logic [1:0] sr_mode,
  input  logic       zero_det,
  input  logic       rev_trip,
  output logic       cut
);

  logic cut_q;
  logic set_cut;

  always_comb begin
    set_cut = 1'b0;
    if (in_off) begin
      unique case (sr_mode_e'(sr_mode))
        SR_ACTIVE:  set_cut = zero_det;
        SR_PASSIVE: set_cut = rev_trip;
        default:    set_cut = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           cut_q <= 1'b0;
    else if (start)    cut_q <= 1'b0;
    else if (ending)   cut_q <= 1'b0;
    else if (set_cut)  cut_q <= 1'b1;
  end

  assign cut = cut_q;

  AST_CUT_CLEARS_ON_START: assert property (@(posedge clk) disable iff (rst)
    start |=> !cut_q); // R12

  AST_CUT_ONLY_IN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!in_off && !start) |=> !cut_q); // R6

endmodule

// File: rtl/gate_seq.sv
module gate_seq
  import decay_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_off,
  input  logic              fast,
  input  logic              cut,
  input  logic              sr_disabled,
  input  logic              dir,
  input  logic [GATE_W-1:0] on_gates,
  input  logic              fault,
  output logic [GATE_W-1:0] gate
);

  logic [GATE_W-1:0] target;
  logic [GATE_W-1:0] gate_q;
  logic [GATE_W-1:0] gate_d;

  always_comb begin
    if (!in_off)                target = on_gates;
    else if (sr_disabled || cut) target = '0;
    else if (fast)              target = fast_pattern(dir);
    else                        target = slow_pattern();
  end

  always_comb begin
    if (fault)
      gate_d = '0;
    else if (gate_q != '0 && target != '0 && target != gate_q)
      gate_d = '0;
    else
      gate_d = target;
  end

  always_ff @(posedge clk) begin
    if (rst) gate_q <= '0;
    else     gate_q <= gate_d;
  end

  assign gate = gate_q;

  AST_FAULT_BLANKS: assert property (@(posedge clk) disable iff (rst)
    fault |=> (gate_q == '0)); // R11

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
    (gate_q != '0) |=> (gate_q == '0 || gate_q == $past(gate_q))); // R10

  AST_DISABLED_DARK: assert property (@(posedge clk) disable iff (rst)
    (in_off && sr_disabled) |=> (gate_q == '0)); // R9

endmodule

// File: rtl/decay_ctrl.sv
module decay_ctrl
  import decay_pkg::*;
#(
  parameter int OFF_W   = 8,
  parameter int CODE_W  = 4,
  parameter int FD_TICK = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              off_start,
  input  logic [OFF_W-1:0]  off_len,
  input  logic              decay_mixed,
  input  logic [CODE_W-1:0] fd_code,
  input  logic [1:0]        sr_mode,
  input  logic              cur_dir,
  input  logic              zero_det,
  input  logic              rev_trip,
  input  logic              ot_fault,
  input  logic              uv_fault,
  input  logic [3:0]        on_gates,
  output logic [3:0]        gate_en,
  output logic              off_phase
);

  logic in_off;
  logic fast;
  logic ending;
  logic cut;

  decay_timer #(
    .OFF_W  (OFF_W),
    .CODE_W (CODE_W),
    .FD_TICK(FD_TICK)
  ) timer_i (
    .clk    (clk),
    .rst    (rst),
    .start  (off_start),
    .mixed  (decay_mixed),
    .off_len(off_len),
    .fd_code(fd_code),
    .in_off (in_off),
    .fast   (fast),
    .ending (ending)
  );

  sr_guard guard_i (
    .clk     (clk),
    .rst     (rst),
    .start   (off_start),
    .ending  (ending),
    .in_off  (in_off),
    .sr_mode (sr_mode),
    .zero_det(zero_det),
    .rev_trip(rev_trip),
    .cut     (cut)
  );

  gate_seq seq_i (
    .clk        (clk),
    .rst        (rst),
    .in_off     (in_off),
    .fast       (fast),
    .cut        (cut),
    .sr_disabled(sr_mode[1]),
    .dir        (cur_dir),
    .on_gates   (on_gates),
    .fault      (ot_fault | uv_fault),
    .gate       (gate_en)
  );

  assign off_phase = in_off;

  AST_FAST_ONLY_MIXED: assert property (@(posedge clk) disable iff (rst)
    (!decay_mixed && in_off && !cut && sr_mode == 2'b00 && !ot_fault && !uv_fault
     && gate_en != 4'b0000 && off_phase) |=> (gate_en != 4'b0110 || $past(on_gates) == 4'b0110)); // R3

endmodule

// File: tb/decay_ctrl_tb.sv
module decay_ctrl_tb_top;

  localparam int OFF_W   = 8;
  localparam int CODE_W  = 4;
  localparam int FD_TICK = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              off_start = 1'b0;
  logic [OFF_W-1:0]  off_len = '0;
  logic              decay_mixed = 1'b0;
  logic [CODE_W-1:0] fd_code = '0;
  logic [1:0]        sr_mode = 2'b00;
  logic              cur_dir = 1'b1;
  logic              zero_det = 1'b0;
  logic              rev_trip = 1'b0;
  logic              ot_fault = 1'b0;
  logic              uv_fault = 1'b0;
  logic [3:0]        on_gates = 4'b0000;
  logic [3:0]        gate_en;
  logic              off_phase;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  logic [4:0] exp_q[$];

  always #2 clk = ~clk;

  decay_ctrl #(.OFF_W(OFF_W), .CODE_W(CODE_W), .FD_TICK(FD_TICK)) dut_i (
    .clk(clk), .rst(rst), .off_start(off_start), .off_len(off_len),
    .decay_mixed(decay_mixed), .fd_code(fd_code), .sr_mode(sr_mode),
    .cur_dir(cur_dir), .zero_det(zero_det), .rev_trip(rev_trip),
    .ot_fault(ot_fault), .uv_fault(uv_fault), .on_gates(on_gates),
    .gate_en(gate_en), .off_phase(off_phase)
  );

  // Reference model: counts elapsed off-time cycles upward.
  bit       m_in = 0;
  int       m_el = 0;
  bit       m_cut = 0;
  bit [3:0] m_gate = '0;

  always @(posedge clk) begin
    bit [3:0] tgt;
    bit       m_fast;
    bit       m_end;
    bit       m_set;
    int       len;
    if (rst) begin
      m_in = 0; m_el = 0; m_cut = 0; m_gate = '0;
    end else begin
      len    = (off_len == 0) ? 1 : int'(off_len);
      m_fast = m_in && decay_mixed && (m_el < int'(fd_code) * FD_TICK);
      if (!m_in)                   tgt = on_gates;
      else if (sr_mode[1] || m_cut) tgt = 4'b0000;
      else if (m_fast)             tgt = cur_dir ? 4'b0110 : 4'b1001;
      else                         tgt = 4'b1010;
      if (ot_fault || uv_fault)                              m_gate = 4'b0000;
      else if (m_gate != 0 && tgt != 0 && tgt != m_gate)     m_gate = 4'b0000;
      else                                                   m_gate = tgt;
      m_end = m_in && (m_el + 1 >= len);
      m_set = m_in && ((sr_mode == 2'b00 && zero_det) || (sr_mode == 2'b01 && rev_trip));
      if (off_start)   m_cut = 0;
      else if (m_end)  m_cut = 0;
      else if (m_set)  m_cut = 1;
      if (off_start) begin
        m_in = 1; m_el = 0;
      end else if (m_in) begin
        if (m_end) begin m_in = 0; m_el = 0; end
        else m_el = m_el + 1;
      end
    end
    exp_q.push_back({m_in, m_gate});
  end

  // Monitor: pops one expected item per cycle, away from the active edge.
  always @(negedge clk) begin
    logic [4:0] e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      checks++;
      if ({off_phase, gate_en} !== e) begin
        errors++;
        $display("FAIL %s: {off_phase,gate_en} actual=%b_%b expected=%b_%b at %0t",
                 cur_req, off_phase, gate_en, e[4], e[3:0], $time);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic window(string req, int len, bit mixed, int code, int mode, bit dir,
                        int zero_at, int rev_at, int fault_at, bit use_uv, int restart_at);
    cur_req     = req;
    off_len     = OFF_W'(len);
    decay_mixed = mixed;
    fd_code     = CODE_W'(code);
    sr_mode     = 2'(mode);
    cur_dir     = dir;
    on_gates    = dir ? 4'b1001 : 4'b0110;
    off_start   = 1'b1;
    @(negedge clk);
    for (int c = 1; c < len + 6; c++) begin
      off_start = (c == restart_at);
      zero_det  = (c == zero_at);
      rev_trip  = (c == rev_at);
      ot_fault  = (c == fault_at) && !use_uv;
      uv_fault  = (c == fault_at) && use_uv;
      @(negedge clk);
    end
    off_start = 0; zero_det = 0; rev_trip = 0; ot_fault = 0; uv_fault = 0;
    idle(3);
  endtask

  initial begin
    cur_req = "R1";
    idle(4);
    rst = 1'b0;
    idle(2);

    cur_req = "R2";
    on_gates = 4'b1001; idle(3);
    on_gates = 4'b0110; idle(3);
    on_gates = 4'b0000; idle(2);
    on_gates = 4'b1001; idle(3);

    cur_req = "R10";
    for (int i = 0; i < 6; i++) begin
      on_gates = (i % 2 == 0) ? 4'b0110 : 4'b1010;
      idle(2);
    end

    window("R3",  10, 0, 5,  0, 1, -1, -1, -1, 0, -1);
    window("R3",  10, 0, 0,  1, 0, -1, -1, -1, 0, -1);
    window("R4",  20, 1, 2,  0, 1, -1, -1, -1, 0, -1);
    window("R4",  20, 1, 3,  1, 0, -1, -1, -1, 0, -1);
    window("R5",  10, 1, 15, 0, 1, -1, -1, -1, 0, -1);
    window("R5",  10, 1, 0,  0, 0, -1, -1, -1, 0, -1);
    window("R5",   8, 1, 2,  0, 1, -1, -1, -1, 0, -1);
    window("R6",   1, 0, 0,  0, 1, -1, -1, -1, 0, -1);
    window("R6",   0, 0, 0,  0, 0, -1, -1, -1, 0, -1);
    window("R6",   5, 1, 1,  0, 1, -1, -1, -1, 0, -1);
    window("R7",  12, 0, 0,  0, 1,  3, -1, -1, 0, -1);
    window("R7",  12, 1, 2,  0, 0, -1,  3, -1, 0, -1);
    window("R7",  12, 1, 1,  0, 1,  6,  2, -1, 0, -1);
    window("R8",  12, 0, 0,  1, 1, -1,  4, -1, 0, -1);
    window("R8",  12, 1, 3,  1, 0,  2, -1, -1, 0, -1);
    window("R8",  12, 1, 1,  1, 1,  3,  7, -1, 0, -1);
    window("R9",  10, 1, 1,  2, 1,  2,  3, -1, 0, -1);
    window("R9",  10, 0, 0,  3, 0, -1, -1, -1, 0, -1);
    window("R11", 12, 1, 1,  0, 1, -1, -1,  2, 0, -1);
    window("R11", 12, 0, 0,  1, 0, -1, -1,  6, 1, -1);
    window("R12", 14, 0, 0,  0, 1,  2, -1, -1, 0,  5);
    window("R12", 14, 1, 1,  1, 0, -1,  3, -1, 0,  6);

    cur_req = "R11";
    on_gates = 4'b1001; idle(3);
    uv_fault = 1'b1; idle(3);
    uv_fault = 1'b0; idle(3);

    cur_req = "R1";
    rst = 1'b1; idle(3);
    rst = 1'b0; idle(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule